// File: doc/BRIEF.md
# Block Security Configuration Register Bank

This block is the software-visible configuration side of a block-granular memory security filter. Memory behind the filter is split into equal power-of-two blocks. Each block owns one bit in a table of 32-bit words: 0 marks the block secure and 1 marks it non-secure. Software fills the table through a single window register that is addressed by an index pointer. The index can step forward on its own after each full-word access and wraps at the end of the table, so the whole table can be streamed through one address. The filter datapath sits outside this block and reads the table and the control bits straight from the output ports.

The bank also holds a control register with an error-response select, an auto-increment enable and a sticky lockdown bit. It holds an interrupt status bit with enable, set and clear registers, and two registers that capture details of the first blocked transfer the filter reports. Fixed identification registers complete the bank. Configuration registers answer only secure masters. The identification registers answer every master. Byte and halfword accesses are supported.

The bus is a single-cycle register port. A write takes effect at the clock edge of the cycle in which `bus_sel` and `bus_wr` are high. Read data is valid combinationally in the cycle of a read. Sub-word write data is right-aligned in `bus_wdata`, and the byte lane is `bus_addr[1:0]`.

Top module: `blk_sec_cfg_bank`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0x00000100, the index (0x18) reads 0, interrupt status (0x20) reads 0, interrupt enable (0x28) reads 1, both capture registers (0x2C, 0x30) read 0, every table word is 0, and `irq` is 0.
- R2: Offset 0x10 reads the number of table words minus one. Offset 0x14 reads log2(block size in bytes) minus 5.
- R3: Only control bits 4 (error response, driven on `blk_err_resp`), 8 (index auto-increment) and 31 (lockdown) can be written. All other control bits read as 0.
- R4: A write to the index register stores the written 32-bit value modulo the number of table words.
- R5: Offset 0x1C reads or writes the table word selected by the index. Table word k appears on `lut_flat[32k+31:32k]`. Only after a full-word access (`bus_size` 2 or 3), and only while control bit 8 is set, the index advances by one and wraps from the last word to 0.
- R6: A non-secure access (`bus_secure`=0) to any offset below 0xFD0 reads 0 and has no effect. The identification registers stay readable by non-secure masters.
- R7: The identification registers at 0xFD0 to 0xFFC, taken in rising address order, read 0x04, 0x00, 0x00, 0x00, 0x60, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R8: While lockdown is set, writes to the control register, the table window and the interrupt enable register are ignored, and an ignored table write does not advance the index. Only reset clears lockdown.
- R9: `bus_size` 0 is a byte access and 1 is a halfword access. A sub-word write to the control, index or table window register merges into the current value of that register. A sub-word write to any other register fills the remaining bytes with zeros.
- R10: A sub-word read returns the addressed lanes of the register value, right-aligned, with the upper bits zero.
- R11: Writing 1 to bit 0 of 0x34 sets interrupt status. Writing 1 to bit 0 of 0x24 clears it. Bit 0 of 0x28 is the enable. `irq` is high exactly when both status and enable are 1.
- R12: A fault report (`flt_valid`) while status is 0 stores `flt_addr` in 0x2C and `flt_attr` in 0x30, and sets status. Reports that arrive while status is 1 leave both capture registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_secure | input | 1 | Access comes from a secure master |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_addr | input | 12 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data, right-aligned for sub-word writes |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| flt_valid | input | 1 | Filter reports a blocked transfer |
| flt_addr | input | 32 | Address of the blocked transfer |
| flt_attr | input | 32 | Attributes of the blocked transfer |
| irq | output | 1 | Interrupt request |
| blk_err_resp | output | 1 | Blocked transfers get an error response |
| lut_flat | output | NWORDS*32 | Whole security table, word 0 in the low bits |

## Verification
The bench builds the bank with 256-byte blocks over 24 KiB, which gives three table words. Because three is not a power of two, both the modulo on index writes (including the all-ones value, which reduces to 0) and the wrap of auto-increment past word 2 are exercised against a real remainder rather than a bit truncation. The block-size register then reads 3, and the maximum index register reads 2.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  localparam logic [9:0] W_CTRL  = 10'h000;
  localparam logic [9:0] W_MAX   = 10'h004;
  localparam logic [9:0] W_CFG   = 10'h005;
  localparam logic [9:0] W_IDX   = 10'h006;
  localparam logic [9:0] W_LUT   = 10'h007;
  localparam logic [9:0] W_STAT  = 10'h008;
  localparam logic [9:0] W_CLR   = 10'h009;
  localparam logic [9:0] W_EN    = 10'h00A;
  localparam logic [9:0] W_INFO1 = 10'h00B;
  localparam logic [9:0] W_INFO2 = 10'h00C;
  localparam logic [9:0] W_SET   = 10'h00D;
  localparam logic [9:0] W_ID0   = 10'h3F4;

  localparam logic [31:0] CTRL_WMASK = 32'h8000_0110;
  localparam logic [31:0] CTRL_RST   = 32'h0000_0100;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  function automatic logic [7:0] id_byte(input logic [3:0] n);
    case (n)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h60;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h1B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] size);
    case (size)
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_HALF: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] merge_lanes(input logic [31:0] old_v,
                                              input logic [31:0] wdata,
                                              input logic [1:0]  size,
                                              input logic [1:0]  lane);
    logic [4:0]  sh;
    logic [31:0] m;
    sh = {lane, 3'b000};
    m  = lane_mask(size) << sh;
    if (size[1]) merge_lanes = wdata;
    else         merge_lanes = (old_v & ~m) | ((wdata << sh) & m);
  endfunction

  function automatic logic [31:0] pick_lanes(input logic [31:0] r,
                                             input logic [1:0]  size,
                                             input logic [1:0]  lane);
    logic [4:0] sh;
    sh = {lane, 3'b000};
    pick_lanes = (r >> sh) & lane_mask(size);
  endfunction

endpackage

// File: rtl/bsc_lut_store.sv
module bsc_lut_store #(
  parameter int unsigned NWORDS = 4,
  parameter int unsigned IW     = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   idx_load,
  input  logic [31:0]            idx_wdata,
  input  logic                   word_load,
  input  logic [31:0]            word_wdata,
  input  logic                   idx_step,
  output logic [IW-1:0]          idx_q,
  output logic [31:0]            cur_word,
  output logic [NWORDS*32-1:0]   lut_flat
);

  logic [IW-1:0] idx_d;
  logic [31:0]   idx_mod;

  assign idx_mod = idx_wdata % NWORDS;

  always_comb begin
    idx_d = idx_q;
    if (idx_load) begin
      idx_d = idx_mod[IW-1:0];
    end else if (idx_step) begin
      if (32'(idx_q) == NWORDS - 1) idx_d = '0;
      else                          idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic        wen;
    logic [31:0] word_q;
    assign wen = word_load && (32'(idx_q) == w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (wen) word_q <= word_wdata;
    end
    assign lut_flat[w*32 +: 32] = word_q;
  end

  assign cur_word = lut_flat[32'(idx_q)*32 +: 32];

endmodule

// File: rtl/bsc_irq_unit.sv
module bsc_irq_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_set,
  input  logic        sw_clr,
  input  logic        en_load,
  input  logic        en_wdata,
  input  logic        flt_valid,
  input  logic [31:0] flt_addr,
  input  logic [31:0] flt_attr,
  output logic        stat_q,
  output logic        en_q,
  output logic [31:0] info1_q,
  output logic [31:0] info2_q
);

  logic stat_d;
  logic en_d;
  logic capture;

  assign capture = flt_valid && !stat_q;

  always_comb begin
    stat_d = stat_q;
    if (sw_clr)                 stat_d = 1'b0;
    else if (sw_set || capture) stat_d = 1'b1;
    en_d = en_load ? en_wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      en_q   <= 1'b1;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info1_q <= '0;
      info2_q <= '0;
    end else if (capture) begin
      info1_q <= flt_addr;
      info2_q <= flt_attr;
    end
  end

endmodule

// File: rtl/blk_sec_cfg_bank.sv
module blk_sec_cfg_bank
  import bsc_pkg::*;
#(
  parameter  int unsigned MEM_BYTES = 32768,
  parameter  int unsigned BLK_BYTES = 256,
  localparam int unsigned NWORDS    = (MEM_BYTES / BLK_BYTES + 31) / 32,
  localparam int unsigned IW        = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic                 bus_secure,
  input  logic [1:0]           bus_size,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 flt_valid,
  input  logic [31:0]          flt_addr,
  input  logic [31:0]          flt_attr,
  output logic                 irq,
  output logic                 blk_err_resp,
  output logic [NWORDS*32-1:0] lut_flat
);

  localparam logic [31:0] MAX_VAL = 32'(NWORDS - 1);
  localparam logic [31:0] CFG_VAL = 32'($clog2(BLK_BYTES) - 5);

  logic [9:0]    word_ofs;
  logic [1:0]    lane;
  logic          acc_ok, wr_ok, rd_ok, locked;
  logic [31:0]   old_val, wval, rval;
  logic [31:0]   ctrl_q, ctrl_d;
  logic          ctrl_load, idx_load, word_load, idx_step;
  logic          sw_set, sw_clr, en_load;
  logic [IW-1:0] idx_q;
  logic [31:0]   cur_word;
  logic          irq_stat, irq_en;
  logic [31:0]   info1_q, info2_q;

  assign word_ofs = bus_addr[11:2];
  assign lane     = bus_addr[1:0];
  assign acc_ok   = bus_sel && (bus_secure || (word_ofs >= W_ID0));
  assign wr_ok    = acc_ok && bus_wr;
  assign rd_ok    = acc_ok && !bus_wr;
  assign locked   = ctrl_q[31];

  always_comb begin
    case (word_ofs)
      W_CTRL:  old_val = ctrl_q;
      W_IDX:   old_val = 32'(idx_q);
      W_LUT:   old_val = cur_word;
      default: old_val = '0;
    endcase
  end

  assign wval      = merge_lanes(old_val, bus_wdata, bus_size, lane);
  assign ctrl_load = wr_ok && (word_ofs == W_CTRL) && !locked;
  assign idx_load  = wr_ok && (word_ofs == W_IDX);
  assign word_load = wr_ok && (word_ofs == W_LUT) && !locked;
  assign idx_step  = bus_size[1] && ctrl_q[8] && (word_ofs == W_LUT) &&
                     (rd_ok || word_load);
  assign sw_set    = wr_ok && (word_ofs == W_SET) && wval[0];
  assign sw_clr    = wr_ok && (word_ofs == W_CLR) && wval[0];
  assign en_load   = wr_ok && (word_ofs == W_EN) && !locked;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_load) ctrl_d = wval & CTRL_WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end

  bsc_lut_store #(.NWORDS(NWORDS), .IW(IW)) lut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_load   (idx_load),
    .idx_wdata  (wval),
    .word_load  (word_load),
    .word_wdata (wval),
    .idx_step   (idx_step),
    .idx_q      (idx_q),
    .cur_word   (cur_word),
    .lut_flat   (lut_flat)
  );

  bsc_irq_unit irq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_set    (sw_set),
    .sw_clr    (sw_clr),
    .en_load   (en_load),
    .en_wdata  (wval[0]),
    .flt_valid (flt_valid),
    .flt_addr  (flt_addr),
    .flt_attr  (flt_attr),
    .stat_q    (irq_stat),
    .en_q      (irq_en),
    .info1_q   (info1_q),
    .info2_q   (info2_q)
  );

  always_comb begin
    rval = '0;
    if (word_ofs >= W_ID0) begin
      rval = {24'h0, id_byte(4'(word_ofs - W_ID0))};
    end else begin
      case (word_ofs)
        W_CTRL:  rval = ctrl_q;
        W_MAX:   rval = MAX_VAL;
        W_CFG:   rval = CFG_VAL;
        W_IDX:   rval = 32'(idx_q);
        W_LUT:   rval = cur_word;
        W_STAT:  rval = {31'h0, irq_stat};
        W_EN:    rval = {31'h0, irq_en};
        W_INFO1: rval = info1_q;
        W_INFO2: rval = info2_q;
        default: rval = '0;
      endcase
    end
  end

  assign bus_rdata    = rd_ok ? pick_lanes(rval, bus_size, lane) : '0;
  assign irq          = irq_stat && irq_en;
  assign blk_err_resp = ctrl_q[4];

endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
  parameter int unsigned NWORDS = 4,
  parameter int unsigned IW     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic                 bus_secure,
  input logic [1:0]           bus_size,
  input logic [11:0]          bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          ctrl_q,
  input logic [IW-1:0]        idx_q,
  input logic [NWORDS*32-1:0] lut_flat,
  input logic                 irq_stat,
  input logic [31:0]          info1_q
);

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[31] |=> ctrl_q[31]); // R8

  AST_LOCK_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[31] && bus_sel && bus_wr && bus_addr[11:2] == 10'h000)
    |=> $stable(ctrl_q)); // R8

  AST_NS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_secure && bus_addr < 12'hFD0)
    |=> ($stable(ctrl_q) && $stable(lut_flat) && $stable(idx_q))); // R6

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx_q) < NWORDS); // R4

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_secure && bus_addr[11:2] == 10'h00D &&
     bus_size[1] && bus_wdata[0]) |=> irq_stat); // R11

  AST_INFO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat |=> $stable(info1_q)); // R12

endmodule

bind blk_sec_cfg_bank bsc_checker #(.NWORDS(NWORDS), .IW(IW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_secure (bus_secure),
  .bus_size   (bus_size),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .ctrl_q     (ctrl_q),
  .idx_q      (idx_q),
  .lut_flat   (lut_flat),
  .irq_stat   (irq_stat),
  .info1_q    (info1_q)
);

// File: tb/blk_sec_cfg_bank_tb_top.sv
`timescale 1ns/1ps
module blk_sec_cfg_bank_tb_top;

  localparam int unsigned MEMB = 24576;
  localparam int unsigned BLKB = 256;
  localparam int unsigned NW   = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0, bus_wr = 1'b0, bus_secure = 1'b1;
  logic [1:0]      bus_size = 2'd2;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            flt_valid = 1'b0;
  logic [31:0]     flt_addr = '0, flt_attr = '0;
  logic            irq, blk_err_resp;
  logic [NW*32-1:0] lut_flat;

  int checks = 0;
  int errors = 0;
  logic mon_req = 1'b0;
  logic [31:0] exp_q[$];
  int          kind_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  blk_sec_cfg_bank #(.MEM_BYTES(MEMB), .BLK_BYTES(BLKB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_secure(bus_secure), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flt_valid(flt_valid),
    .flt_addr(flt_addr), .flt_attr(flt_attr), .irq(irq),
    .blk_err_resp(blk_err_resp), .lut_flat(lut_flat)
  );

  // monitor: kind 0 read data, 1 irq, 2 error-response select, 3 table word 1
  always @(negedge clk) begin
    if (mon_req) begin
      logic [31:0] act, ex;
      int k;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
      end else begin
        ex = exp_q.pop_front();
        k  = kind_q.pop_front();
        t  = tag_q.pop_front();
        case (k)
          0:       act = bus_rdata;
          1:       act = {31'h0, irq};
          2:       act = {31'h0, blk_err_resp};
          default: act = lut_flat[63:32];
        endcase
        if (act !== ex) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, act, ex);
        end
      end
    end
  end

  task automatic idle_fields();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_secure = 1'b1; bus_size = 2'd2;
    bus_addr = '0; bus_wdata = '0; flt_valid = 1'b0; mon_req = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic [1:0] sz = 2'd2, input logic sec = 1'b1);
    @(posedge clk); #1;
    idle_fields();
    bus_sel = 1'b1; bus_wr = 1'b1; bus_secure = sec; bus_size = sz;
    bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] ex, input string t,
                    input logic [1:0] sz = 2'd2, input logic sec = 1'b1);
    @(posedge clk); #1;
    idle_fields();
    bus_sel = 1'b1; bus_secure = sec; bus_size = sz; bus_addr = a;
    exp_q.push_back(ex); kind_q.push_back(0); tag_q.push_back(t);
    mon_req = 1'b1;
  endtask

  task automatic probe(input int k, input logic [31:0] ex, input string t);
    @(posedge clk); #1;
    idle_fields();
    exp_q.push_back(ex); kind_q.push_back(k); tag_q.push_back(t);
    mon_req = 1'b1;
  endtask

  task automatic fault(input logic [31:0] a, input logic [31:0] t);
    @(posedge clk); #1;
    idle_fields();
    flt_valid = 1'b1; flt_addr = a; flt_attr = t;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(12'h000, 32'h100, "R1 ctrl");
    rd(12'h028, 32'h1,   "R1 enable");
    rd(12'h020, 32'h0,   "R1 status");
    probe(1, 32'h0,      "R1 irq");
    rd(12'h02C, 32'h0,   "R1 info1");
    rd(12'h030, 32'h0,   "R1 info2");
    rd(12'h018, 32'h0,   "R1 index");
    probe(3, 32'h0,      "R1 table word");
    // R2 geometry
    rd(12'h010, 32'h2, "R2 max index");
    rd(12'h014, 32'h3, "R2 block size");
    // R7 identification, R6 non-secure visibility
    rd(12'hFD0, 32'h04, "R7 id0");
    rd(12'hFE0, 32'h60, "R7 id4");
    rd(12'hFFC, 32'hB1, "R7 id11");
    rd(12'hFE8, 32'h1B, "R6 ns id6", 2'd2, 1'b0);
    rd(12'hFF4, 32'hF0, "R7 ns id9", 2'd2, 1'b0);
    // R4 modulo
    wr(12'h018, 32'd7);           rd(12'h018, 32'd1, "R4 idx 7 mod 3");
    wr(12'h018, 32'hFFFF_FFFF);   rd(12'h018, 32'd0, "R4 idx all-ones");
    wr(12'h018, 32'd2);           rd(12'h018, 32'd2, "R4 idx 2");
    // R5 streaming with auto-increment and wrap
    wr(12'h018, 32'd0);
    wr(12'h01C, 32'h1111_0001);
    wr(12'h01C, 32'h2222_0002);
    wr(12'h01C, 32'h3333_0003);
    rd(12'h018, 32'd0, "R5 idx wrapped after writes");
    rd(12'h01C, 32'h1111_0001, "R5 word0");
    rd(12'h01C, 32'h2222_0002, "R5 word1");
    rd(12'h01C, 32'h3333_0003, "R5 word2");
    rd(12'h018, 32'd0, "R5 idx wrapped after reads");
    probe(3, 32'h2222_0002, "R5 table output word1");
    // R9 / R10 sub-word table access, no step
    wr(12'h018, 32'd1);
    wr(12'h01E, 32'h1234, 2'd1);
    rd(12'h018, 32'd1, "R5 no step on halfword");
    rd(12'h01F, 32'h12, "R10 byte lane3", 2'd0);
    rd(12'h01C, 32'h0002, "R10 half lane0", 2'd1);
    rd(12'h018, 32'd1, "R5 no step on sub-word read");
    rd(12'h01C, 32'h1234_0002, "R9 table merge");
    rd(12'h018, 32'd2, "R5 step on word read");
    // R3 control mask
    wr(12'h000, 32'h7FFF_FFFF);   rd(12'h000, 32'h110, "R3 ctrl mask");
    probe(2, 32'h1, "R3 err resp on");
    wr(12'h000, 32'h0);           rd(12'h000, 32'h0, "R3 ctrl zero");
    probe(2, 32'h0, "R3 err resp off");
    wr(12'h001, 32'h01, 2'd0);    rd(12'h000, 32'h100, "R9 ctrl byte1 merge");
    wr(12'h000, 32'h10, 2'd0);    rd(12'h000, 32'h110, "R9 ctrl byte0 merge");
    rd(12'h001, 32'h01, "R10 ctrl byte1", 2'd0);
    wr(12'h000, 32'h0);
    wr(12'h018, 32'd0);
    rd(12'h01C, 32'h1111_0001, "R5 read without autoinc");
    rd(12'h018, 32'd0, "R5 idx held without autoinc");
    wr(12'h000, 32'h100);
    // R9 zero fill
    wr(12'h029, 32'h01, 2'd0);    rd(12'h028, 32'h0, "R9 enable zero fill");
    wr(12'h028, 32'h1);
    // R6 non-secure rejection
    wr(12'h000, 32'h0, 2'd2, 1'b0);  rd(12'h000, 32'h100, "R6 ns ctrl write");
    rd(12'h000, 32'h0, "R6 ns ctrl read", 2'd2, 1'b0);
    wr(12'h018, 32'd2, 2'd2, 1'b0);  rd(12'h018, 32'd0, "R6 ns idx write");
    wr(12'h034, 32'h1, 2'd2, 1'b0);  probe(1, 32'h0, "R6 ns set irq");
    rd(12'h020, 32'h0, "R6 ns set status");
    // R11 interrupt
    wr(12'h034, 32'h1);  rd(12'h020, 32'h1, "R11 set status");
    probe(1, 32'h1, "R11 irq high");
    wr(12'h028, 32'h0);  probe(1, 32'h0, "R11 irq masked");
    rd(12'h020, 32'h1, "R11 status kept");
    wr(12'h028, 32'h1);  probe(1, 32'h1, "R11 irq unmasked");
    wr(12'h024, 32'h1);  rd(12'h020, 32'h0, "R11 clear status");
    probe(1, 32'h0, "R11 irq cleared");
    // R12 capture
    fault(32'h0000_0440, 32'h0001_0003);
    rd(12'h020, 32'h1, "R12 status set");
    rd(12'h02C, 32'h0000_0440, "R12 info1");
    rd(12'h030, 32'h0001_0003, "R12 info2");
    fault(32'h0000_0880, 32'h5);
    rd(12'h02C, 32'h0000_0440, "R12 info1 held");
    rd(12'h030, 32'h0001_0003, "R12 info2 held");
    wr(12'h024, 32'h1);
    fault(32'h0000_0880, 32'h5);
    rd(12'h02C, 32'h0000_0880, "R12 recapture");
    wr(12'h024, 32'h1);
    // R8 lockdown
    wr(12'h000, 32'h8000_0100);  rd(12'h000, 32'h8000_0100, "R8 lock set");
    wr(12'h000, 32'h0);          rd(12'h000, 32'h8000_0100, "R8 ctrl frozen");
    wr(12'h018, 32'd1);
    wr(12'h01C, 32'h0000_DEAD);
    rd(12'h018, 32'd1, "R8 no step on ignored write");
    rd(12'h01C, 32'h1234_0002, "R8 table frozen");
    wr(12'h028, 32'h0);          rd(12'h028, 32'h1, "R8 enable frozen");
    wr(12'h034, 32'h1);          probe(1, 32'h1, "R8 set still works");
    @(posedge clk); #1 idle_fields();
    @(posedge clk); #1;
    finish_run();
  end

endmodule